// File: doc/BRIEF.md
# Round-Robin Write-Back Bus Arbiter

An out-of-order core whose common result bus is narrower than its number of execution latency paths needs something that decides, every cycle, which finished instructions may broadcast their tags. This block places a small first-in first-out buffer behind each completion channel. A completing instruction is therefore parked, not discarded, while the buses are taken. Each cycle a circular scan over the buffers hands out up to `NUM_BUS` write-back slots. The scan takes at most one tag per buffer, and always the oldest in that buffer.

The scan does not restart from a fixed channel. It resumes from the buffer where the previous cycle's scan ended. If every slot was used, that is the buffer just after the last one granted. Otherwise it is the same starting buffer, because a full lap ends where it began. No channel can therefore be starved by busier neighbours. When a buffer is full, a completion presented on its channel is refused, and the stall output for that channel goes high so the producer holds its tag.

Top module: `rrwb_arbiter`

## Requirements
- R1: Tags from one channel are written back in the order the buffer accepted them.
- R2: The number of valid write-back slots in a cycle equals the smaller of `NUM_BUS` and the number of nonempty buffers.
- R3: No buffer supplies more than one tag in a cycle, so all valid slots in a cycle carry tags from distinct channels.
- R4: Slot j carries the head of the j-th nonempty buffer, counting in circular channel order from the scan pointer.
- R5: After a cycle in which all `NUM_BUS` slots are used, the scan pointer is the channel after the last one granted, wrapping from `NUM_CH-1` to 0. After any other cycle, including one with no grants, the pointer is unchanged.
- R6: Grants are decided from the buffer contents held at the start of the cycle, and the granted entries are removed at the next rising clock edge. A tag accepted at an edge can be granted in the following cycle at the earliest.
- R7: Each buffer holds `DEPTH` tags. While buffer i is full, a completion presented on channel i is not stored and `cmp_stall[i]` is high. Otherwise `cmp_stall[i]` is low and the completion is stored.
- R8: While reset is asserted, and directly after it, all buffers are empty, the scan pointer is 0, and no slot is valid.
- R9: Valid slots are packed from slot 0 upward, and the tag field of every invalid slot is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid | input | NUM_CH | One completion offered per channel |
| cmp_tag | input | NUM_CH*TAG_W | Instruction tag per channel; channel i occupies bits i*TAG_W upward |
| cmp_stall | output | NUM_CH | The channel's buffer is full and its offered completion was refused |
| wb_valid | output | NUM_BUS | Write-back slot holds a granted tag |
| wb_tag | output | NUM_BUS*TAG_W | Granted tag per slot; slot j occupies bits j*TAG_W upward |

## Verification
The bench drives all four channels with more completions than the two buses can drain. This fills the buffers and exercises refusal. A design that wrote into a full buffer would overwrite a waiting tag, and that tag would never appear on the bus. Reference queues in the bench check the order of every granted tag. A pointer that reset to channel 0 each cycle, or that skipped past the buffer where the scan stopped, would reorder the slots against those queues. Directed cycles cover grants with every buffer empty, a lone arrival into empty buffers (which must not be granted in the same cycle), and a reset applied in the middle of traffic.

// File: rtl/rrwb_pkg.sv
package rrwb_pkg;

  // Advance a channel index by one, wrapping at n.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // Channel reached after stepping off places from base in circular order.
  function automatic int unsigned circ_idx(input int unsigned base, input int unsigned off,
                                           input int unsigned n);
    return (base + off) % n;
  endfunction

endpackage

// File: rtl/rrwb_chan_buf.sv
module rrwb_chan_buf #(
  parameter int TAG_W = 6,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             pop,
  output logic [TAG_W-1:0] head_tag,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             push;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign push     = in_valid && !full;
  assign head_tag = mem[rd_ptr];

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_step(wr_ptr);
      if (pop)  rd_ptr <= ptr_step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: occupancy never exceeds the buffer depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R3: the scan only removes from a buffer that holds something
  a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R7: a refused completion while nothing drains leaves the buffer full
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

endmodule

// File: rtl/rrwb_scan.sv
module rrwb_scan
  import rrwb_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_BUS = 2,
  parameter int PW      = 2
) (
  input  logic [PW-1:0]                ptr,
  input  logic [NUM_CH-1:0]            ready,
  output logic [NUM_CH-1:0]            pop,
  output logic [NUM_BUS-1:0]           slot_valid,
  output logic [NUM_BUS-1:0][PW-1:0]   slot_ch,
  output logic [PW-1:0]                ptr_next
);

  always_comb begin
    int unsigned used;
    int unsigned idx;
    pop        = '0;
    slot_valid = '0;
    slot_ch    = '0;
    ptr_next   = ptr;
    used       = 0;
    for (int i = 0; i < NUM_CH; i++) begin
      idx = circ_idx(int'(ptr), i, NUM_CH);
      if (ready[idx] && used < NUM_BUS) begin
        pop[idx] = 1'b1;
        for (int j = 0; j < NUM_BUS; j++) begin
          if (j == int'(used)) begin
            slot_valid[j] = 1'b1;
            slot_ch[j]    = PW'(idx);
          end
        end
        used = used + 1;
        if (used == NUM_BUS) ptr_next = PW'(wrap_inc(idx, NUM_CH));
      end
    end
  end

endmodule

// File: rtl/rrwb_arbiter.sv
module rrwb_arbiter #(
  parameter int NUM_CH  = 4,
  parameter int NUM_BUS = 2,
  parameter int DEPTH   = 4,
  parameter int TAG_W   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         cmp_valid,
  input  logic [NUM_CH*TAG_W-1:0]   cmp_tag,
  output logic [NUM_CH-1:0]         cmp_stall,
  output logic [NUM_BUS-1:0]        wb_valid,
  output logic [NUM_BUS*TAG_W-1:0]  wb_tag
);
  localparam int PW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [TAG_W-1:0]            head [NUM_CH];
  logic [NUM_CH-1:0]           empty, full, ready, pop;
  logic [PW-1:0]               ptr, ptr_next;
  logic [NUM_BUS-1:0]          slot_valid;
  logic [NUM_BUS-1:0][PW-1:0]  slot_ch;

  // Named internal events for the checks below.
  logic grant_any;
  int   n_ready;
  assign grant_any = |slot_valid;
  assign n_ready   = $countones(ready);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_buf
    rrwb_chan_buf #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (cmp_valid[c]),
      .in_tag   (cmp_tag[c*TAG_W +: TAG_W]),
      .pop      (pop[c]),
      .head_tag (head[c]),
      .empty    (empty[c]),
      .full     (full[c])
    );
  end

  assign ready     = ~empty;
  assign cmp_stall = cmp_valid & full;

  rrwb_scan #(.NUM_CH(NUM_CH), .NUM_BUS(NUM_BUS), .PW(PW)) u_scan (
    .ptr        (ptr),
    .ready      (ready),
    .pop        (pop),
    .slot_valid (slot_valid),
    .slot_ch    (slot_ch),
    .ptr_next   (ptr_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_next;
  end

  assign wb_valid = slot_valid;
  always_comb begin
    for (int j = 0; j < NUM_BUS; j++)
      wb_tag[j*TAG_W +: TAG_W] = slot_valid[j] ? head[slot_ch[j]] : '0;
  end

  // R2: never more grants than buses
  a_r2_bus_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pop) <= NUM_BUS);
  // R2: every bus is used while enough buffers are waiting
  a_r2_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wb_valid) == ((n_ready > NUM_BUS) ? NUM_BUS : n_ready));
  // R3: one removal per granted slot, so no buffer is taken twice
  a_r3_one_per_buf: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pop) == $countones(wb_valid));
  // R5: an idle cycle leaves the scan position alone
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_any |=> $stable(ptr));
  // R9: valid slots are packed from slot 0
  a_r9_packed: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid & (wb_valid + 1'b1)) == '0);

endmodule

// File: tb/rrwb_arbiter_test.sv
`timescale 1ns/100ps
module rrwb_arbiter_test;
  localparam int C  = 4;
  localparam int K  = 2;
  localparam int D  = 4;
  localparam int TW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [C-1:0]    cmp_valid = '0;
  logic [C*TW-1:0] cmp_tag = '0;
  logic [C-1:0]    cmp_stall;
  logic [K-1:0]    wb_valid;
  logic [K*TW-1:0] wb_tag;

  always #2.5 clk = ~clk;

  rrwb_arbiter #(.NUM_CH(C), .NUM_BUS(K), .DEPTH(D), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .cmp_stall(cmp_stall), .wb_valid(wb_valid), .wb_tag(wb_tag));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int stall_seen = 0;

  // Reference queues built from the requirements.
  logic [TW-1:0] mq [C][D];
  int            mcnt [C];
  int            mptr;
  logic [3:0]    seq [C];

  localparam logic [C-1:0] VEC [24] = '{
    4'b0001, 4'b0000, 4'b0011, 4'b0110, 4'b1111, 4'b1000, 4'b0000, 4'b0101,
    4'b1010, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0100, 4'b1001, 4'b0010,
    4'b1111, 4'b0111, 4'b1110, 4'b0000, 4'b0000, 4'b0000, 4'b1100, 4'b0000};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < C; c++) begin
      mcnt[c] = 0;
      seq[c]  = '0;
    end
    mptr = 0;
  endtask

  task automatic cycle(input logic [C-1:0] vmask, input string req);
    logic [K-1:0]    exp_v;
    logic [K*TW-1:0] exp_t;
    logic [C-1:0]    exp_s, grant, acc;
    int              used, newp;
    @(negedge clk);
    cmp_valid = vmask;
    for (int c = 0; c < C; c++) cmp_tag[c*TW +: TW] = {c[1:0], seq[c]};
    #1;
    exp_v = '0; exp_t = '0; grant = '0; used = 0; newp = mptr;
    for (int i = 0; i < C; i++) begin
      int idx;
      idx = (mptr + i) % C;
      if (mcnt[idx] > 0 && used < K) begin
        exp_v[used] = 1'b1;
        exp_t[used*TW +: TW] = mq[idx][0];
        grant[idx] = 1'b1;
        used++;
        if (used == K) newp = (idx + 1) % C;
      end
    end
    for (int c = 0; c < C; c++) begin
      exp_s[c] = vmask[c] && (mcnt[c] == D);
      acc[c]   = vmask[c] && (mcnt[c] < D);
    end
    if (exp_s != 0) stall_seen++;
    check(wb_valid == exp_v, {"R2 ", req}, "slot valids", 32'(wb_valid), 32'(exp_v));
    check(wb_tag == exp_t, "R1 R4 R5 R9", "slot tags", 32'(wb_tag), 32'(exp_t));
    check(cmp_stall == exp_s, "R7", "stall", 32'(cmp_stall), 32'(exp_s));
    if (wb_valid == 2'b11)
      check(wb_tag[TW-1 -: 2] != wb_tag[2*TW-1 -: 2], "R3", "distinct channels",
            32'(wb_tag), 32'(exp_t));
    @(posedge clk);
    for (int c = 0; c < C; c++) begin
      if (grant[c]) begin
        for (int e = 0; e < D - 1; e++) mq[c][e] = mq[c][e+1];
        mcnt[c]--;
      end
      if (acc[c]) begin
        mq[c][mcnt[c]] = {c[1:0], seq[c]};
        mcnt[c]++;
        seq[c] = seq[c] + 1'b1;
      end
    end
    mptr = newp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    // R8: reset state
    #1;
    check(wb_valid == '0, "R8", "valids in reset", 32'(wb_valid), 0);
    check(cmp_stall == '0, "R8", "stall in reset", 32'(cmp_stall), 0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Table walk
    for (int v = 0; v < 24; v++) cycle(VEC[v], "table");

    // R6: a lone arrival into empty buffers is not granted in its own cycle
    for (int n = 0; n < 6; n++) cycle('0, "drain");
    cycle(4'b1000, "R6 arrival");
    check(wb_valid == '0, "R6", "no same-cycle grant", 32'(wb_valid), 0);
    cycle('0, "R6 next");

    // R5: idle cycles with all buffers empty
    cycle('0, "R5 idle");
    cycle('0, "R5 idle");

    // R7: overload until buffers fill, then drain in order
    for (int n = 0; n < 8; n++) cycle('1, "R7 burst");
    check(stall_seen > 0, "R7", "stall reached", 32'(stall_seen), 1);
    for (int n = 0; n < 20; n++) cycle('0, "R1 drain");
    check(wb_valid == '0, "R1", "buffers drained", 32'(wb_valid), 0);

    // R8: reset in the middle of traffic
    for (int n = 0; n < 3; n++) cycle(4'b0111, "pre-reset");
    @(negedge clk);
    rst_n = 1'b0;
    cmp_valid = '1;
    #1;
    check(wb_valid == '0, "R8", "valids after mid reset", 32'(wb_valid), 0);
    check(cmp_stall == '0, "R8", "stall after mid reset", 32'(cmp_stall), 0);
    model_reset();
    @(posedge clk);
    @(negedge clk) begin rst_n = 1'b1; cmp_valid = '0; end
    cycle(4'b0010, "R8 post");
    cycle(4'b0001, "R8 post");
    for (int n = 0; n < 4; n++) cycle('0, "R8 post");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule